// File: doc/BRIEF.md
# Microsequencer with OR-Dispatch Decode

This block produces the next control-store address for a microcoded 16-bit processor. It holds the current microaddress in a register. On each clock it loads that register with the branch target carried by the current microinstruction. Instruction decode needs no lookup ROM and no adder. Selected bits of the instruction register are ORed into the low bits of a branch target. A jump therefore lands in a 16-entry table that the microcode must place on a 16-word boundary.

There are two dispatch sources. The first comes from a microinstruction that loads the instruction register from memory data. That load arms a one-shot dispatch, and the dispatch acts on the branch of the microinstruction that follows. The second is a secondary decode function. When its code runs, it latches a 4-bit class value computed from several instruction fields. A later branch that asks for it then ORs in that value, which clears it. The control store itself, the ALU and the datapath lie outside this block.

Top module: `microseq`

## Requirements
- R1: When neither dispatch applies, the microaddress after a clock edge equals the `uc_next` value present before that edge.
- R2: A cycle with `uc_ld_ir`=1 arms a dispatch. The branch taken at the end of that loading cycle is plain. The dispatch is applied to the branch of the next cycle that has `uc_ld_ir`=0.
- R3: A firing IR dispatch ORs four instruction bits into the branch target. Numbering bits MSB-first (bit 0 = `ir_q[15]`), instruction bit 0 goes to microaddress bit 3, bit 5 (`ir_q[10]`) to bit 2, bit 6 (`ir_q[9]`) to bit 1 and bit 7 (`ir_q[8]`) to bit 0. The other target bits pass unchanged. A word of all ones on a base of 020 octal gives 037 octal, and a word with those four bits clear gives the base itself (entry 0).
- R4: `ir_q` takes `mem_data` at the end of a cycle with `uc_ld_ir`=1 and holds its value otherwise.
- R5: A second load while a dispatch is still pending fires nothing in that cycle and restarts the one-cycle delay. The dispatch that follows uses the newly loaded word.
- R6: An IR dispatch fires once. The branch after a firing is plain unless a new load has occurred.
- R7: `uc_sec_fn`=1 latches a 4-bit class value from the current `ir_q`. If `ir_q[15]`=1 the value is {`ir_q[7:6]`, `ir_q[5:4]`}. Otherwise it is {2'b11, `ir_q[12:11]`}.
- R8: A branch with `uc_sec_use`=1 ORs the latched class value into microaddress bits 3..0 and clears it. If no value is latched, `uc_sec_use` has no effect.
- R9: Synchronous reset sets the microaddress and `ir_q` to 0 and clears both pending dispatches.
- R10: When an IR dispatch and a secondary dispatch fall on the same branch, both values are ORed into the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uc_next | input | AW | Branch target field of the current microinstruction |
| uc_ld_ir | input | 1 | Current microinstruction loads the instruction register from memory data |
| uc_sec_fn | input | 1 | Current microinstruction runs the secondary decode function |
| uc_sec_use | input | 1 | Current branch requests the secondary dispatch |
| mem_data | input | 16 | Memory data word |
| ir_q | output | 16 | Instruction register |
| uaddr | output | AW | Registered current microaddress |

## Verification
Every result arrives one clock edge after the microinstruction that causes it. The microaddress and `ir_q` reflect the inputs held before that edge. A dispatch armed by a load appears in the microaddress two edges after the load, and a secondary value appears one edge after the branch that uses it. The bench changes inputs on the falling edge and advances its reference model one step per rising edge. It compares both outputs at the following falling edge, so each expected value is lined up with the edge that produces it. The stimulus includes back-to-back loads, both dispatches on one branch and a reset in the middle of the run.

// File: rtl/microseq_pkg.sv
package microseq_pkg;
  localparam int IR_W   = 16;
  localparam int DISP_W = 4;
  // Instruction bit numbers (MSB-first) feeding dispatch bits DISP_W-1 .. 0
  localparam int DISP_SRC [DISP_W] = '{0, 5, 6, 7};
endpackage

// File: rtl/microseq_ir.sv
module microseq_ir
  import microseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [IR_W-1:0]   mem_data,
  output logic [IR_W-1:0]   ir_q,
  output logic              fire,
  output logic [DISP_W-1:0] disp_bits
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q  <= '0;
      armed <= 1'b0;
    end else begin
      if (ld) ir_q <= mem_data;
      if (ld)        armed <= 1'b1;
      else if (fire) armed <= 1'b0;
    end
  end

  assign fire = armed & ~ld;

  for (genvar g = 0; g < DISP_W; g++) begin : g_pick
    assign disp_bits[DISP_W-1-g] = ir_q[IR_W-1-DISP_SRC[g]];
  end

  p_ir_load_r4: assert property (@(posedge clk) disable iff (rst)
    ld |=> ir_q == $past(mem_data));
  p_ir_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !ld |=> $stable(ir_q));
  p_one_shot_r6: assert property (@(posedge clk) disable iff (rst)
    fire |=> !fire);
endmodule

// File: rtl/microseq_sec.sv
module microseq_sec
  import microseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              fn,
  input  logic              use_req,
  input  logic [IR_W-1:0]   ir_q,
  output logic              hit,
  output logic [DISP_W-1:0] sec_bits
);
  logic              valid;
  logic [DISP_W-1:0] cls_d;
  logic [DISP_W-1:0] cls_q;

  always_comb begin
    if (ir_q[IR_W-1]) cls_d = {ir_q[7:6], ir_q[5:4]};
    else              cls_d = {2'b11, ir_q[12:11]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      cls_q <= '0;
    end else if (fn) begin
      valid <= 1'b1;
      cls_q <= cls_d;
    end else if (hit) begin
      valid <= 1'b0;
    end
  end

  assign hit      = use_req & valid;
  assign sec_bits = hit ? cls_q : '0;

  p_sec_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && !fn) |=> !hit);
  p_sec_latch_r7: assert property (@(posedge clk) disable iff (rst)
    fn |=> cls_q == $past(cls_d));
endmodule

// File: rtl/microseq_addr.sv
module microseq_addr
  import microseq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     base,
  input  logic              fire,
  input  logic [DISP_W-1:0] disp_bits,
  input  logic              hit,
  input  logic [DISP_W-1:0] sec_bits,
  output logic [AW-1:0]     uaddr
);
  localparam int HI_W = AW - DISP_W;

  logic [DISP_W-1:0] low_or;
  logic [AW-1:0]     nxt;

  assign low_or = (fire ? disp_bits : '0) | sec_bits;

  if (HI_W > 0) begin : g_wide
    assign nxt = base | {{HI_W{1'b0}}, low_or};
  end else begin : g_narrow
    assign nxt = base | low_or[AW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) uaddr <= '0;
    else     uaddr <= nxt;
  end

  p_plain_branch_r1: assert property (@(posedge clk) disable iff (rst)
    (!fire && !hit) |=> uaddr == $past(base));
  p_base_kept_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (uaddr & $past(base)) == $past(base));
endmodule

// File: rtl/microseq.sv
module microseq
  import microseq_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   uc_next,
  input  logic            uc_ld_ir,
  input  logic            uc_sec_fn,
  input  logic            uc_sec_use,
  input  logic [IR_W-1:0] mem_data,
  output logic [IR_W-1:0] ir_q,
  output logic [AW-1:0]   uaddr
);
  logic              fire;
  logic [DISP_W-1:0] disp_bits;
  logic              hit;
  logic [DISP_W-1:0] sec_bits;

  microseq_ir u_ir (
    .clk(clk), .rst(rst), .ld(uc_ld_ir), .mem_data(mem_data),
    .ir_q(ir_q), .fire(fire), .disp_bits(disp_bits)
  );

  microseq_sec u_sec (
    .clk(clk), .rst(rst), .fn(uc_sec_fn), .use_req(uc_sec_use),
    .ir_q(ir_q), .hit(hit), .sec_bits(sec_bits)
  );

  microseq_addr #(.AW(AW)) u_addr (
    .clk(clk), .rst(rst), .base(uc_next), .fire(fire),
    .disp_bits(disp_bits), .hit(hit), .sec_bits(sec_bits), .uaddr(uaddr)
  );

  p_fire_after_load_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(uc_ld_ir) && !$past(rst) && !uc_ld_ir) |-> fire);
  p_reload_defers_r5: assert property (@(posedge clk) disable iff (rst)
    uc_ld_ir |-> !fire);
  p_reset_state_r9: assert property (@(posedge clk)
    $past(rst) |-> (uaddr == '0 && ir_q == '0 && !fire && !hit));
endmodule

// File: tb/microseq_bench.sv
`timescale 1ns/1ps
module microseq_bench;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] uc_next = '0;
  logic          uc_ld_ir = 1'b0;
  logic          uc_sec_fn = 1'b0;
  logic          uc_sec_use = 1'b0;
  logic [15:0]   mem_data = '0;
  logic [15:0]   ir_q;
  logic [AW-1:0] uaddr;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  // reference state
  int m_ua = 0, m_ir = 0, m_cls = 0;
  bit m_armed = 0, m_sv = 0;

  always #2.5 clk = ~clk;

  microseq #(.AW(AW)) u_microseq (
    .clk(clk), .rst(rst), .uc_next(uc_next), .uc_ld_ir(uc_ld_ir),
    .uc_sec_fn(uc_sec_fn), .uc_sec_use(uc_sec_use), .mem_data(mem_data),
    .ir_q(ir_q), .uaddr(uaddr)
  );

  function automatic int ir_field(int w);
    int v = 0;
    if ((w >> 15) & 1) v += 8;
    if ((w >> 10) & 1) v += 4;
    if ((w >> 9) & 1)  v += 2;
    if ((w >> 8) & 1)  v += 1;
    return v;
  endfunction

  function automatic int class_of(int w);
    if ((w >> 15) & 1) return (w >> 4) & 15;
    return 12 + ((w >> 11) & 3);
  endfunction

  task automatic check(string req, int act, int exp, string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, int nxt, bit ld, bit fn, bit su, int md, bit r = 0);
    bit fire_m;
    int low;
    @(negedge clk);
    rst = r; uc_next = nxt[AW-1:0]; uc_ld_ir = ld; uc_sec_fn = fn;
    uc_sec_use = su; mem_data = md[15:0];
    if (r) begin
      m_ua = 0; m_ir = 0; m_armed = 0; m_sv = 0; m_cls = 0;
    end else begin
      fire_m = m_armed && !ld;
      low = 0;
      if (fire_m) low = low | ir_field(m_ir);
      if (su && m_sv) low = low | m_cls;
      m_ua = nxt | low;
      if (fn) begin m_sv = 1; m_cls = class_of(m_ir); end
      else if (su && m_sv) m_sv = 0;
      if (ld) m_armed = 1; else if (fire_m) m_armed = 0;
      if (ld) m_ir = md & 16'hFFFF;
    end
    @(negedge clk);
    check(req, int'(uaddr), m_ua, "uaddr");
    check(req, int'(ir_q), m_ir, "ir_q");
    #0.1;
  endtask

  initial begin
    #(5.0 * 5000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    step("R9", 'h3FF, 1, 1, 1, 'hFFFF, 1);
    step("R9", 'h3FF, 1, 1, 1, 'hFFFF, 1);
    // R1: plain branches
    step("R1", 'h123, 0, 0, 0, 0);
    step("R1", 'h2AA, 0, 0, 0, 'h5555);
    step("R8", 'h150, 0, 0, 1, 0); // R8 use with nothing latched
    // R2/R3: AND-class all ones into table at 020 octal
    step("R2", 'o100, 1, 0, 0, 'hFFFF);
    step("R3", 'o20, 0, 0, 0, 0);
    step("R6", 'o20, 0, 0, 0, 0);
    // R3: entry 0
    step("R2", 'o200, 1, 0, 0, 'h78FF);
    step("R3", 'o40, 0, 0, 0, 0);
    // R3: single bits
    step("R4", 0, 1, 0, 0, 'h8000);
    step("R3", 'o60, 0, 0, 0, 0);
    step("R4", 0, 1, 0, 0, 'h0400);
    step("R3", 'o60, 0, 0, 0, 0);
    step("R4", 0, 1, 0, 0, 'h0200);
    step("R3", 'o60, 0, 0, 0, 0);
    step("R4", 0, 1, 0, 0, 'h0100);
    step("R3", 'o60, 0, 0, 0, 0);
    // R3: OR onto base with low bits already set
    step("R4", 0, 1, 0, 0, 'h8000);
    step("R3", 'h305, 0, 0, 0, 0);
    // R5: back-to-back loads
    step("R5", 'h010, 1, 0, 0, 'hFFFF);
    step("R5", 'h020, 1, 0, 0, 'h0200);
    step("R5", 'h040, 0, 0, 0, 0);
    step("R6", 'h080, 0, 0, 0, 0);
    // R7/R8: secondary, ALU class
    step("R4", 'h001, 1, 0, 0, 'h80B0);
    step("R7", 'h100, 0, 1, 0, 0);
    step("R1", 'h200, 0, 0, 0, 0);
    step("R8", 'h100, 0, 0, 1, 0);
    step("R8", 'h100, 0, 0, 1, 0);
    // R7: non-ALU class
    step("R4", 'h001, 1, 0, 0, 'h1000);
    step("R7", 'h000, 0, 1, 0, 0);
    step("R8", 'h3F0, 0, 0, 1, 0);
    // R10: both on one branch
    step("R4", 0, 1, 0, 0, 'h8040);
    step("R7", 'h200, 0, 1, 0, 0);
    step("R4", 0, 1, 0, 0, 'h0100);
    step("R10", 'h200, 0, 0, 1, 0);
    // R9: reset mid-run clears pending dispatch
    step("R4", 0, 1, 1, 0, 'hFFFF);
    step("R9", 'h155, 0, 0, 0, 0, 1);
    step("R9", 'h100, 0, 0, 1, 0);
    step("R1", 'h0AA, 0, 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule